// File: doc/BRIEF.md
# Serial Management Frame Master

This block runs one management transaction at a time over a two-wire serial link: a management clock and a data line. The data line leaves the block as three separate signals (output value, output enable and input value), so the pad tristate buffer sits outside. A host pulses `start_i` with a read/write select, a 5-bit device address, a 5-bit register address and, for writes, 16 bits of data. The block builds the whole frame, then returns a one-cycle `done_o` pulse together with the read data and a no-response flag.

The frame is built from bit slots. Each slot has a low half followed by a high half, and each half lasts `HALF_CYC` system clock cycles. The driven data value changes only at the start of a slot, while the management clock is low. Read data is sampled in the last system cycle of a slot's high half. If the addressed device does not pull the line low during the second turnaround slot of a read, the block runs 32 recovery slots and reports all-ones data with the no-response flag set. The input `mdio_in_i` is assumed to be already synchronous to `clk`.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset and between frames, `mdc_o` is 1, `mdio_oe_o` is 0, `busy_o` and `done_o` are 0, `rdata_o` is 0 and `no_resp_o` is 0.
- R2: Slots 0 to 31 of every frame drive the data output to 1 with the output enable set.
- R3: Slots 32 and 33 drive 0 then 1. Slots 34 and 35 carry the opcode, which is 1,0 for a read and 0,1 for a write.
- R4: Slots 36 to 40 carry the device address and slots 41 to 45 carry the register address, each most significant bit first.
- R5: In a write, slots 46 and 47 drive 1 then 0, and slots 48 to 63 carry the write data most significant bit first. Slot 64 has the output enable cleared, and the frame has 65 slots.
- R6: In a read, the output enable is 0 from slot 46 to the end of the frame. When `mdio_in_i` is 0 at the end of slot 47, slots 48 to 63 capture read data most significant bit first, one more slot follows (65 slots in all), and `rdata_o` presents the captured word.
- R7: In a read where `mdio_in_i` is 1 at the end of slot 47's high half, the block runs 32 further slots (80 slots in all). It then sets `rdata_o` to 16'hFFFF and `no_resp_o` to 1.
- R8: While a frame is running, each low half and each high half of `mdc_o` lasts exactly `HALF_CYC` cycles. `mdio_out_o` and `mdio_oe_o` do not change while `mdc_o` stays high.
- R9: A start accepted at clock edge E raises `busy_o` from edge E. `done_o` is high for exactly one cycle, directly after edge E + 2·`HALF_CYC`·N, where N is the slot count, and `busy_o` stays high through that cycle.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running frame is unchanged, and no new frame follows it.
- R11: `rdata_o` and `no_resp_o` change only in the cycle where `done_o` is high. A write keeps `rdata_o` and clears `no_resp_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for one transaction |
| rd_i | input | 1 | 1 = read, 0 = write |
| dev_addr_i | input | 5 | Device address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result, held until the next done |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| busy_o | output | 1 | Frame in progress, from start through done |
| no_resp_o | output | 1 | Last read saw no turnaround-low |
| mdc_o | output | 1 | Management clock, idles high |
| mdio_out_o | output | 1 | Data line value to drive |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_in_i | input | 1 | Data line value seen at the pad |

## Verification
The bench samples on falling system clock edges, so every registered output is read half a cycle after the edge that set it. It counts sampled cycles from the start pulse: `busy_o` must be high at the first sample, and `done_o` must appear at sample 2·`HALF_CYC`·N+1 and be gone at the next. A monitor records the driven value and enable at each rising `mdc_o`, times every half period between `mdc_o` transitions, and acts as the responding device. It changes `mdio_in_i` at each falling `mdc_o`, which is a full half period before the block samples it. Read results are compared at the done sample and again after idle cycles and following writes.

// File: rtl/mgmt_frame_pkg.sv
// Package: shared widths and slot positions for the management frame master.
// Assumes a single-frame-at-a-time master; slot numbers count from 0 at the
// first preamble slot.
package mgmt_frame_pkg;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int SLOT_W      = 7;
    localparam int PRE_LEN     = 32;
    localparam int ST_FIRST    = PRE_LEN;            // 32
    localparam int OP_FIRST    = ST_FIRST + 2;       // 34
    localparam int DEV_FIRST   = OP_FIRST + 2;       // 36
    localparam int REG_FIRST   = DEV_FIRST + ADDR_W; // 41
    localparam int TA_FIRST    = REG_FIRST + ADDR_W; // 46
    localparam int TA_SECOND   = TA_FIRST + 1;       // 47
    localparam int DAT_FIRST   = TA_FIRST + 2;       // 48
    localparam int DAT_LAST    = DAT_FIRST + DATA_W - 1; // 63
    localparam int TAIL_SLOT   = DAT_LAST + 1;       // 64
    localparam int RECOV_LEN   = 32;
    localparam int SILENT_LAST = TA_SECOND + RECOV_LEN; // 79
endpackage

// File: rtl/mgmt_half_timer.sv
// Module: half-period timer. Counts HALF_CYC system cycles per half of the
// management clock and tells which half is current. Assumes HALF_CYC >= 1
// and that restart_i arrives only while run_i is low.
module mgmt_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic high_o,
    output logic slot_end_o
);
    localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_CYC - 1);

    logic [PH_W-1:0] phase_q;
    logic            high_q;
    logic            half_end;

    assign half_end   = run_i && (phase_q == PH_LAST);
    assign high_o     = high_q;
    assign slot_end_o = half_end && high_q;

    // Purpose: advance the phase counter and flip the half at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            high_q  <= 1'b0;
        end else if (restart_i) begin
            phase_q <= '0;
            high_q  <= 1'b0;
        end else if (run_i) begin
            if (half_end) begin
                phase_q <= '0;
                high_q  <= ~high_q;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mgmt_slot_encoder.sv
// Module: slot encoder. Maps the current slot number and the latched command
// onto the value to drive and the output enable. Purely combinational; assumes
// the slot number is stable for a whole slot.
module mgmt_slot_encoder
    import mgmt_frame_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] dev_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              bit_o,
    output logic              oe_o
);
    localparam int AIDX_W = $clog2(ADDR_W);
    localparam int DIDX_W = $clog2(DATA_W);

    int                sl;
    logic [AIDX_W-1:0] dev_idx;
    logic [AIDX_W-1:0] reg_idx;
    logic [DIDX_W-1:0] dat_idx;

    // Purpose: bit indices for the most-significant-first fields.
    always_comb begin
        sl      = int'(slot_i);
        dev_idx = AIDX_W'(REG_FIRST - 1 - sl);
        reg_idx = AIDX_W'(TA_FIRST - 1 - sl);
        dat_idx = DIDX_W'(DAT_LAST - sl);
    end

    // Purpose: select value and enable for the current slot.
    always_comb begin
        bit_o = 1'b1;
        oe_o  = 1'b1;
        if (sl < ST_FIRST) begin
            bit_o = 1'b1;
        end else if (sl == ST_FIRST) begin
            bit_o = 1'b0;
        end else if (sl == ST_FIRST + 1) begin
            bit_o = 1'b1;
        end else if (sl == OP_FIRST) begin
            bit_o = rd_i;
        end else if (sl == OP_FIRST + 1) begin
            bit_o = ~rd_i;
        end else if (sl < REG_FIRST) begin
            bit_o = dev_i[dev_idx];
        end else if (sl < TA_FIRST) begin
            bit_o = reg_i[reg_idx];
        end else if (rd_i) begin
            oe_o = 1'b0;
        end else if (sl == TA_FIRST) begin
            bit_o = 1'b1;
        end else if (sl == TA_SECOND) begin
            bit_o = 1'b0;
        end else if (sl <= DAT_LAST) begin
            bit_o = wdata_i[dat_idx];
        end else begin
            oe_o = 1'b0;
        end
    end
endmodule

// File: rtl/mgmt_frame_ctrl.sv
// Module: frame control. Accepts a command when idle, steps the slot counter
// at each slot end, checks the turnaround, shifts in read data and produces
// done, results and the no-response flag. Assumes mdio_in_i is synchronous.
module mgmt_frame_ctrl
    import mgmt_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] dev_i,
    input  logic [ADDR_W-1:0] reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              slot_end_i,
    input  logic              mdio_in_i,
    output logic              accept_o,
    output logic              run_o,
    output logic              done_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              cmd_rd_o,
    output logic [ADDR_W-1:0] cmd_dev_o,
    output logic [ADDR_W-1:0] cmd_reg_o,
    output logic [DATA_W-1:0] cmd_wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              no_resp_o
);
    logic              run_q, done_q, silent_q, rd_q, no_resp_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ADDR_W-1:0] dev_q, reg_q;
    logic [DATA_W-1:0] wdata_q, shift_q, rdata_q;
    int                sl;
    logic              at_last;

    assign accept_o    = start_i && !run_q && !done_q;
    assign sl          = int'(slot_q);
    assign at_last     = (rd_q && silent_q) ? (sl == SILENT_LAST) : (sl == TAIL_SLOT);
    assign run_o       = run_q;
    assign done_o      = done_q;
    assign slot_o      = slot_q;
    assign cmd_rd_o    = rd_q;
    assign cmd_dev_o   = dev_q;
    assign cmd_reg_o   = reg_q;
    assign cmd_wdata_o = wdata_q;
    assign rdata_o     = rdata_q;
    assign no_resp_o   = no_resp_q;

    // Purpose: latch the command and sequence slots until the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            done_q    <= 1'b0;
            silent_q  <= 1'b0;
            rd_q      <= 1'b0;
            no_resp_q <= 1'b0;
            slot_q    <= '0;
            dev_q     <= '0;
            reg_q     <= '0;
            wdata_q   <= '0;
            shift_q   <= '0;
            rdata_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                run_q    <= 1'b1;
                slot_q   <= '0;
                silent_q <= 1'b0;
                shift_q  <= '0;
                rd_q     <= rd_i;
                dev_q    <= dev_i;
                reg_q    <= reg_i;
                wdata_q  <= wdata_i;
            end else if (run_q && slot_end_i) begin
                if (rd_q && !silent_q && sl == TA_SECOND && mdio_in_i) begin
                    silent_q <= 1'b1;
                end
                if (rd_q && !silent_q && sl >= DAT_FIRST && sl <= DAT_LAST) begin
                    shift_q <= {shift_q[DATA_W-2:0], mdio_in_i};
                end
                if (at_last) begin
                    run_q     <= 1'b0;
                    done_q    <= 1'b1;
                    no_resp_q <= rd_q && silent_q;
                    if (rd_q) begin
                        rdata_q <= silent_q ? '1 : shift_q;
                    end
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mgmt_frame_master.sv
// Module: top of the serial management frame master. Wires the half-period
// timer, the frame control and the slot encoder, and shapes the pin outputs.
// Assumes HALF_CYC >= 1 and a synchronous mdio_in_i.
module mgmt_frame_master
    import mgmt_frame_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              no_resp_o,
    output logic              mdc_o,
    output logic              mdio_out_o,
    output logic              mdio_oe_o,
    input  logic              mdio_in_i
);
    logic              accept, run, high, slot_end, done;
    logic              cmd_rd, enc_bit, enc_oe;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] cmd_dev, cmd_reg;
    logic [DATA_W-1:0] cmd_wdata;

    mgmt_half_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (accept),
        .run_i      (run),
        .high_o     (high),
        .slot_end_o (slot_end)
    );

    mgmt_frame_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rd_i        (rd_i),
        .dev_i       (dev_addr_i),
        .reg_i       (reg_addr_i),
        .wdata_i     (wdata_i),
        .slot_end_i  (slot_end),
        .mdio_in_i   (mdio_in_i),
        .accept_o    (accept),
        .run_o       (run),
        .done_o      (done),
        .slot_o      (slot),
        .cmd_rd_o    (cmd_rd),
        .cmd_dev_o   (cmd_dev),
        .cmd_reg_o   (cmd_reg),
        .cmd_wdata_o (cmd_wdata),
        .rdata_o     (rdata_o),
        .no_resp_o   (no_resp_o)
    );

    mgmt_slot_encoder enc_i (
        .slot_i  (slot),
        .rd_i    (cmd_rd),
        .dev_i   (cmd_dev),
        .reg_i   (cmd_reg),
        .wdata_i (cmd_wdata),
        .bit_o   (enc_bit),
        .oe_o    (enc_oe)
    );

    // Purpose: pin shaping; the clock and data idle high, enable idles low.
    always_comb begin
        mdc_o      = run ? high : 1'b1;
        mdio_out_o = run ? enc_bit : 1'b1;
        mdio_oe_o  = run && enc_oe;
        busy_o     = run || done;
        done_o     = done;
    end
endmodule

// File: rtl/mgmt_frame_master_chk.sv
// Module: property checker for the frame master, bound to the top module.
// Observes ports only.
module mgmt_frame_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        no_resp_o,
    input logic [15:0] rdata_o,
    input logic        mdc_o,
    input logic        mdio_out_o,
    input logic        mdio_oe_o
);
    // R1: idle keeps the clock high and the line released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mdc_o && !mdio_oe_o));

    // R8: drive value and enable steady across a high half
    a_r8_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_out_o) && $stable(mdio_oe_o)));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy only rises after a start request
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5, R6: the last slot of every frame has the line released
    a_r5_released_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !$past(mdio_oe_o));

    // R7: no response reports all ones
    a_r7_silent_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && no_resp_o) |-> (rdata_o == 16'hFFFF));

    // R11: results move only with done
    a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(rdata_o) && $stable(no_resp_o)));
endmodule

bind mgmt_frame_master mgmt_frame_master_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .no_resp_o  (no_resp_o),
    .rdata_o    (rdata_o),
    .mdc_o      (mdc_o),
    .mdio_out_o (mdio_out_o),
    .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mgmt_frame_master_tb_top.sv
// Bench: directed and seeded random frames, with a responding-device model
// and a pin monitor; expected values come from bench functions.
module mgmt_frame_master_tb_top;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  dev_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        mdio_in_i = 1'b1;
    logic [15:0] rdata_o;
    logic        done_o, busy_o, no_resp_o, mdc_o, mdio_out_o, mdio_oe_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    mgmt_frame_master #(.HALF_CYC(H)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .rd_i       (rd_i),
        .dev_addr_i (dev_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .done_o     (done_o),
        .busy_o     (busy_o),
        .no_resp_o  (no_resp_o),
        .mdc_o      (mdc_o),
        .mdio_out_o (mdio_out_o),
        .mdio_oe_o  (mdio_oe_o),
        .mdio_in_i  (mdio_in_i)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor and responding-device state
    logic        prev_mdc = 1'b1;
    logic        prev_out = 1'b1;
    logic        prev_oe  = 1'b0;
    bit          in_frame = 1'b0;
    bit          seen_fall = 1'b0;
    int          run_len = 0;
    int          slot_n = 0;
    int          half_bad = 0;
    int          steady_bad = 0;
    logic        rec_out [0:127];
    logic        rec_oe  [0:127];
    bit          slv_read = 1'b0;
    bit          slv_ta = 1'b0;
    logic [15:0] slv_data = '0;

    function automatic logic slave_bit(input int k);
        if (!slv_read) return 1'b1;
        if (k == 47) return slv_ta;
        if (k >= 48 && k <= 63) return slv_data[63 - k];
        return 1'b1;
    endfunction

    // Monitor: record bits at rising clock, time halves, drive device bits
    always @(negedge clk) begin
        if (in_frame && mdc_o && prev_mdc &&
            (mdio_out_o !== prev_out || mdio_oe_o !== prev_oe)) steady_bad++;
        if (mdc_o !== prev_mdc) begin
            if (in_frame && seen_fall && run_len != H) half_bad++;
            if (mdc_o) begin
                if (slot_n < 128) begin
                    rec_out[slot_n] = mdio_out_o;
                    rec_oe[slot_n]  = mdio_oe_o;
                end
                slot_n++;
            end else begin
                seen_fall = 1'b1;
                mdio_in_i = slave_bit(slot_n);
            end
            run_len = 1;
        end else begin
            run_len++;
        end
        prev_mdc = mdc_o;
        prev_out = mdio_out_o;
        prev_oe  = mdio_oe_o;
    end

    function automatic logic exp_oe(input int k, input bit rd);
        if (k < 46) return 1'b1;
        if (rd) return 1'b0;
        return (k <= 63);
    endfunction

    function automatic logic exp_out(input int k, input bit rd, input logic [4:0] dv,
                                     input logic [4:0] rg, input logic [15:0] wd);
        if (k < 32) return 1'b1;
        if (k == 32) return 1'b0;
        if (k == 33) return 1'b1;
        if (k == 34) return rd;
        if (k == 35) return !rd;
        if (k <= 40) return dv[40 - k];
        if (k <= 45) return rg[45 - k];
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        return wd[63 - k];
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] dv, input logic [4:0] rg,
                             input logic [15:0] wd, input bit ta, input logic [15:0] sd,
                             input bit poke);
        int cnt = 0;
        int n_exp;
        int e_pre = 0, e_hdr = 0, e_adr = 0, e_tail = 0;
        slot_n = 0; seen_fall = 0; half_bad = 0; steady_bad = 0;
        slv_read = rd; slv_ta = ta; slv_data = sd; mdio_in_i = 1'b1;
        @(negedge clk);
        rd_i = rd; dev_addr_i = dv; reg_addr_i = rg; wdata_i = wd;
        start_i = 1'b1; in_frame = 1'b1;
        forever begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                start_i = 1'b0;
                chk(busy_o === 1'b1, "R9", "busy after start", busy_o, 1);
            end
            if (poke && cnt == 40) begin
                start_i = 1'b1; rd_i = !rd; dev_addr_i = ~dv;
                reg_addr_i = ~rg; wdata_i = ~wd;
            end
            if (poke && cnt == 41) start_i = 1'b0;
            if (done_o === 1'b1 || cnt > 4000) break;
        end
        in_frame = 1'b0;
        n_exp = rd ? (ta ? 80 : 65) : 65;
        chk(cnt == 2 * H * n_exp + 1, rd ? (ta ? "R7" : "R6") : "R5", "done cycle",
            cnt, 2 * H * n_exp + 1);
        chk(slot_n == n_exp, rd ? (ta ? "R7" : "R6") : "R5", "slot count", slot_n, n_exp);
        for (int k = 0; k < n_exp && k < 128; k++) begin
            bit bad;
            bad = (rec_oe[k] !== exp_oe(k, rd));
            if (exp_oe(k, rd) && rec_out[k] !== exp_out(k, rd, dv, rg, wd)) bad = 1;
            if (bad) begin
                if (k < 32) e_pre++;
                else if (k < 36) e_hdr++;
                else if (k < 46) e_adr++;
                else e_tail++;
            end
        end
        chk(e_pre == 0, "R2", "preamble slot errors", e_pre, 0);
        chk(e_hdr == 0, "R3", "start/opcode slot errors", e_hdr, 0);
        chk(e_adr == 0, "R4", "address slot errors", e_adr, 0);
        chk(e_tail == 0, rd ? "R6" : "R5", "turnaround/data slot errors", e_tail, 0);
        chk(half_bad == 0 && steady_bad == 0, "R8", "half timing/steady errors",
            half_bad + steady_bad, 0);
        if (rd) begin
            chk(rdata_o === (ta ? 16'hFFFF : sd), ta ? "R7" : "R6", "read data",
                rdata_o, ta ? 16'hFFFF : sd);
            chk(no_resp_o === ta, ta ? "R7" : "R6", "no response flag", no_resp_o, ta);
        end else begin
            chk(no_resp_o === 1'b0, "R11", "flag after write", no_resp_o, 0);
        end
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R9", "done single cycle",
            {done_o, busy_o}, 0);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy_o === 1'b0, "R10", "no frame after ignored start", busy_o, 0);
        end
    endtask

    // Watchdog
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        void'($urandom(32'd51966));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mdc_o === 1'b1 && mdio_oe_o === 1'b0, "R1", "idle pins", {mdc_o, mdio_oe_o}, 2);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "idle status", {busy_o, done_o}, 0);
        chk(rdata_o === 16'h0 && no_resp_o === 1'b0, "R1", "reset results",
            rdata_o, 0);

        run_frame(1'b0, 5'h1F, 5'h00, 16'hA55A, 1'b0, 16'h0, 1'b0);
        run_frame(1'b1, 5'h00, 5'h1F, 16'h0, 1'b0, 16'h8001, 1'b0);
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0, 1'b1, 16'h1234, 1'b0);
        run_frame(1'b1, 5'h0A, 5'h15, 16'h0, 1'b0, 16'h7FFE, 1'b0);
        last_rd = 16'h7FFE;
        repeat (10) @(negedge clk);
        chk(rdata_o === last_rd, "R11", "read data held while idle", rdata_o, last_rd);
        run_frame(1'b0, 5'h03, 5'h11, 16'h0F0F, 1'b0, 16'h0, 1'b1);
        chk(rdata_o === last_rd, "R11", "write keeps read data", rdata_o, last_rd);
        run_frame(1'b1, 5'h07, 5'h02, 16'h0, 1'b0, 16'hC3C3, 1'b1);

        for (int i = 0; i < 14; i++) begin
            bit          rd = 1'($urandom);
            bit          ta = ($urandom % 4) == 0;
            logic [4:0]  dv = 5'($urandom);
            logic [4:0]  rg = 5'($urandom);
            logic [15:0] wd = 16'($urandom);
            logic [15:0] sd = 16'($urandom);
            run_frame(rd, dv, rg, wd, ta, sd, 1'b0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule